// File: doc/BRIEF.md
# Dual-Clock FIFO with Direction Flag

This block carries data words from a producer running on one clock to a consumer running on an unrelated clock. The producer side offers a write enable, a data word and a full indication. The consumer side offers a read enable and an empty indication. The oldest stored word is always visible on the read data bus while the FIFO is not empty, so a consumer can look at a word before it pops it.

Each side keeps a binary pointer and a Gray-coded copy of it. The Gray copy crosses into the other clock domain through a two-flop synchronizer. Pointers are exactly as wide as the address, with no extra wrap bit. When the two pointers are equal, a per-domain direction flag tells the two cases apart. In the write domain the flag is set by the write that closes the gap. In the read domain it is set by reset and by the read that drains the last word. Full is computed in the write domain and empty in the read domain. Each flag goes active on the local edge that causes it and goes inactive only once the remote pointer has come through the synchronizer.

Top module: `dirflag_fifo`

## Requirements
- R1: While either reset is held and after it is released with no traffic, `rd_empty` is 1 and `wr_full` is 0 (both flags active high).
- R2: Words leave in the order they were accepted. While `rd_empty` is 0, `rd_data` shows the oldest unread word before `rd_en` pops it, and it holds steady until a read is accepted.
- R3: A read request while `rd_empty` is 1 is ignored. The read pointer does not move and no stored word is lost.
- R4: A write request while `wr_full` is 1 is ignored. No stored word is overwritten.
- R5: Starting from a settled FIFO holding k words, with no reads in progress, `wr_full` is 1 on the write-clock cycle right after the write that brings the count to DEPTH, and stays 0 before that. `wr_full` rises only after a write request.
- R6: With no writes in progress, `rd_empty` is 1 on the read-clock cycle right after the read that takes the last word, and stays 0 before that. `rd_empty` rises only after a read request.
- R7: After a read frees a slot in a full FIFO, `wr_full` is still 1 on the next write-clock cycle. It clears within six write-clock cycles.
- R8: After the first write into an empty FIFO, `rd_empty` is still 1 on the next read-clock cycle. It clears within six read-clock cycles, and the written word then appears on `rd_data`.
- R9: Each accepted write or read advances its pointer by one, wrapping from DEPTH-1 to 0. Order is kept across several laps of the storage.
- R10: With writes and reads running at the same time on both clocks, every word arrives exactly once and in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain reset, asynchronous, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | FIFO full, write-domain view |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Read-domain reset, asynchronous, active low |
| rd_en | input | 1 | Read request; pops the word on `rd_data` |
| rd_data | output | DATA_W | Oldest unread word |
| rd_empty | output | 1 | FIFO empty, read-domain view |

## Verification
The assertions assume that both resets are applied together and are released while no requests are active. They also assume that the write clock is never so much faster than the read clock that a synchronized Gray pointer could skip a whole lap of the storage between two samples. The bench keeps both assumptions. It runs 200 MHz and 7 ns clocks that differ by less than a factor of two. It drives requests only at falling edges, well after reset is released. The flag timing checks for R5 and R6 are made only after both synchronizers have settled and only while the other side is idle. Only in that state is the pessimistic flag exact.

// File: rtl/dfifo_pkg.sv
`timescale 1ns/1ps
package dfifo_pkg;
    // number of flops in each pointer synchronizer
    localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/dfifo_sync.sv
`timescale 1ns/1ps
module dfifo_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = dfifo_pkg::SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] stage;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d = sync_q;
        sync_d.stage[0] = din;
        for (int s = 1; s < int'(STAGES); s++) begin
            sync_d.stage[s] = sync_q.stage[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign dout = sync_q.stage[STAGES-1];
endmodule

// File: rtl/dfifo_mem.sv
`timescale 1ns/1ps
module dfifo_mem #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 16,
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] store_q [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) store_q[waddr] <= wdata;
    end

    // read side sees the word at its pointer with no clock delay
    assign rdata = store_q[raddr];
endmodule

// File: rtl/dfifo_wr_ctrl.sv
`timescale 1ns/1ps
module dfifo_wr_ctrl #(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] rd_gray_sync,
    output logic [ADDR_W-1:0] wr_bin,
    output logic [ADDR_W-1:0] wr_gray,
    output logic              full,
    output logic              accept
);
    typedef struct packed {
        logic [ADDR_W-1:0] bin;
        logic [ADDR_W-1:0] gray;
        logic              caught;   // gap closed by a write
    } wstate_t;

    wstate_t st_d, st_q;
    logic [ADDR_W-1:0] rd_bin_sync;
    logic [ADDR_W-1:0] bin_inc;
    logic              full_c;
    logic              accept_c;

    always_comb begin
        rd_bin_sync[ADDR_W-1] = rd_gray_sync[ADDR_W-1];
        for (int i = int'(ADDR_W) - 2; i >= 0; i--) begin
            rd_bin_sync[i] = rd_bin_sync[i+1] ^ rd_gray_sync[i];
        end

        full_c   = (st_q.bin == rd_bin_sync) && st_q.caught;
        accept_c = wr_en && !full_c;
        bin_inc  = st_q.bin + 1'b1;

        st_d = st_q;
        if (accept_c) begin
            st_d.bin  = bin_inc;
            st_d.gray = bin_inc ^ (bin_inc >> 1);
        end
        if (accept_c && (bin_inc == rd_bin_sync)) begin
            st_d.caught = 1'b1;
        end else if (rd_bin_sync != st_q.bin) begin
            st_d.caught = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_bin  = st_q.bin;
    assign wr_gray = st_q.gray;
    assign full    = full_c;
    assign accept  = accept_c;
endmodule

// File: rtl/dfifo_rd_ctrl.sv
`timescale 1ns/1ps
module dfifo_rd_ctrl #(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] wr_gray_sync,
    output logic [ADDR_W-1:0] rd_bin,
    output logic [ADDR_W-1:0] rd_gray,
    output logic              empty
);
    typedef struct packed {
        logic [ADDR_W-1:0] bin;
        logic [ADDR_W-1:0] gray;
        logic              drained;  // gap closed by a read or reset
    } rstate_t;

    localparam rstate_t RESET_ST = '{bin: '0, gray: '0, drained: 1'b1};

    rstate_t st_d, st_q;
    logic [ADDR_W-1:0] wr_bin_sync;
    logic [ADDR_W-1:0] bin_inc;
    logic              empty_c;
    logic              accept_c;

    always_comb begin
        wr_bin_sync[ADDR_W-1] = wr_gray_sync[ADDR_W-1];
        for (int i = int'(ADDR_W) - 2; i >= 0; i--) begin
            wr_bin_sync[i] = wr_bin_sync[i+1] ^ wr_gray_sync[i];
        end

        empty_c  = (st_q.bin == wr_bin_sync) && st_q.drained;
        accept_c = rd_en && !empty_c;
        bin_inc  = st_q.bin + 1'b1;

        st_d = st_q;
        if (accept_c) begin
            st_d.bin  = bin_inc;
            st_d.gray = bin_inc ^ (bin_inc >> 1);
        end
        if (accept_c && (bin_inc == wr_bin_sync)) begin
            st_d.drained = 1'b1;
        end else if (wr_bin_sync != st_q.bin) begin
            st_d.drained = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RESET_ST;
        else        st_q <= st_d;
    end

    assign rd_bin  = st_q.bin;
    assign rd_gray = st_q.gray;
    assign empty   = empty_c;
endmodule

// File: rtl/dirflag_fifo.sv
`timescale 1ns/1ps
module dirflag_fifo #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 16
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_full,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_empty
);
    localparam int unsigned ADDR_W = $clog2(DEPTH);

    logic [ADDR_W-1:0] wr_bin, wr_gray, wr_gray_sync;
    logic [ADDR_W-1:0] rd_bin, rd_gray, rd_gray_sync;
    logic              wr_accept;

    dfifo_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr_ctrl (
        .clk         (wr_clk),
        .rst_n       (wr_rst_n),
        .wr_en       (wr_en),
        .rd_gray_sync(rd_gray_sync),
        .wr_bin      (wr_bin),
        .wr_gray     (wr_gray),
        .full        (wr_full),
        .accept      (wr_accept)
    );

    dfifo_rd_ctrl #(.ADDR_W(ADDR_W)) u_rd_ctrl (
        .clk         (rd_clk),
        .rst_n       (rd_rst_n),
        .rd_en       (rd_en),
        .wr_gray_sync(wr_gray_sync),
        .rd_bin      (rd_bin),
        .rd_gray     (rd_gray),
        .empty       (rd_empty)
    );

    dfifo_sync #(.WIDTH(ADDR_W)) u_sync_w2r (
        .clk  (rd_clk),
        .rst_n(rd_rst_n),
        .din  (wr_gray),
        .dout (wr_gray_sync)
    );

    dfifo_sync #(.WIDTH(ADDR_W)) u_sync_r2w (
        .clk  (wr_clk),
        .rst_n(wr_rst_n),
        .din  (rd_gray),
        .dout (rd_gray_sync)
    );

    dfifo_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
        .wr_clk(wr_clk),
        .we    (wr_accept),
        .waddr (wr_bin),
        .wdata (wr_data),
        .raddr (rd_bin),
        .rdata (rd_data)
    );
endmodule

// File: rtl/dirflag_fifo_chk.sv
`timescale 1ns/1ps
module dirflag_fifo_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4
) (
    input logic              wr_clk,
    input logic              wr_rst_n,
    input logic              wr_en,
    input logic              wr_full,
    input logic [ADDR_W-1:0] wr_ptr,
    input logic              rd_clk,
    input logic              rd_rst_n,
    input logic              rd_en,
    input logic              rd_empty,
    input logic [DATA_W-1:0] rd_data,
    input logic [ADDR_W-1:0] rd_ptr
);
    // R4
    no_overflow_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_en && wr_full) |=> (wr_ptr == $past(wr_ptr)));

    // R3
    no_underflow_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_en && rd_empty) |=> (rd_ptr == $past(rd_ptr)));

    // R9
    wr_ptr_step_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_en && !wr_full) |=> (wr_ptr == ADDR_W'($past(wr_ptr) + 1'b1)));

    // R9
    rd_ptr_step_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_en && !rd_empty) |=> (rd_ptr == ADDR_W'($past(rd_ptr) + 1'b1)));

    // R5
    full_cause_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $rose(wr_full) |-> $past(wr_en));

    // R6
    empty_cause_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        $rose(rd_empty) |-> $past(rd_en));

    // R2
    head_hold_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (!rd_empty && !rd_en) |=> $stable(rd_data));
endmodule

bind dirflag_fifo dirflag_fifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .wr_clk  (wr_clk),
    .wr_rst_n(wr_rst_n),
    .wr_en   (wr_en),
    .wr_full (wr_full),
    .wr_ptr  (wr_bin),
    .rd_clk  (rd_clk),
    .rd_rst_n(rd_rst_n),
    .rd_en   (rd_en),
    .rd_empty(rd_empty),
    .rd_data (rd_data),
    .rd_ptr  (rd_bin)
);

// File: tb/dirflag_fifo_bench.sv
`timescale 1ns/1ps
module dirflag_fifo_bench;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned DEPTH  = 16;

    // step vector: {is_write, count[5:0], exp_full, exp_empty}
    localparam int NSTEP = 10;
    localparam logic [8:0] STEPS [NSTEP] = '{
        {1'b1, 6'd5,  1'b0, 1'b0},
        {1'b0, 6'd5,  1'b0, 1'b1},
        {1'b1, 6'd16, 1'b1, 1'b0},
        {1'b1, 6'd3,  1'b1, 1'b0},   // writes while full: ignored
        {1'b0, 6'd10, 1'b0, 1'b0},
        {1'b1, 6'd10, 1'b1, 1'b0},
        {1'b0, 6'd16, 1'b0, 1'b1},
        {1'b0, 6'd2,  1'b0, 1'b1},   // reads while empty: ignored
        {1'b1, 6'd7,  1'b0, 1'b0},
        {1'b0, 6'd7,  1'b0, 1'b1}
    };

    logic              wr_clk = 1'b0;
    logic              rd_clk = 1'b0;
    logic              wr_rst_n = 1'b0;
    logic              rd_rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              rd_en = 1'b0;
    logic              wr_full;
    logic              rd_empty;
    logic [DATA_W-1:0] rd_data;

    int n_checks = 0;
    int n_errors = 0;
    logic [DATA_W-1:0] exp_q [$];
    logic [DATA_W-1:0] seq = 32'h0000_1000;

    always #2.5 wr_clk = ~wr_clk;
    always #3.5 rd_clk = ~rd_clk;

    dirflag_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dirflag_fifo (
        .wr_clk  (wr_clk),
        .wr_rst_n(wr_rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .wr_full (wr_full),
        .rd_clk  (rd_clk),
        .rd_rst_n(rd_rst_n),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .rd_empty(rd_empty)
    );

    task automatic check(input bit ok, input string req, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge rd_clk);
        repeat (6) @(negedge wr_clk);
    endtask

    // n write attempts; flag timing checked after each accepted write (R5)
    task automatic do_write(input int n);
        bit prev = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge wr_clk);
            if (prev)
                check(wr_full == (exp_q.size() == DEPTH), "R5 full after write",
                      DATA_W'(wr_full), DATA_W'(exp_q.size() == DEPTH));
            wr_en = 1'b1;
            if (!wr_full) begin
                wr_data = seq;
                exp_q.push_back(seq);
                seq++;
                prev = 1;
            end else begin
                wr_data = 32'hBAD0_0000 | DATA_W'(i);
                prev = 0;
            end
        end
        @(negedge wr_clk);
        wr_en = 1'b0;
        if (prev)
            check(wr_full == (exp_q.size() == DEPTH), "R5 full after write",
                  DATA_W'(wr_full), DATA_W'(exp_q.size() == DEPTH));
    endtask

    // n read attempts; data order (R2, R9) and empty timing (R6)
    task automatic do_read(input int n);
        bit prev = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge rd_clk);
            if (prev)
                check(rd_empty == (exp_q.size() == 0), "R6 empty after read",
                      DATA_W'(rd_empty), DATA_W'(exp_q.size() == 0));
            rd_en = 1'b1;
            if (!rd_empty) begin
                check(rd_data == exp_q[0], "R2 R9 read order", rd_data, exp_q[0]);
                void'(exp_q.pop_front());
                prev = 1;
            end else begin
                prev = 0;
            end
        end
        @(negedge rd_clk);
        rd_en = 1'b0;
        if (prev)
            check(rd_empty == (exp_q.size() == 0), "R6 empty after read",
                  DATA_W'(rd_empty), DATA_W'(exp_q.size() == 0));
    endtask

    task automatic push_words(input int n);
        int got = 0;
        while (got < n) begin
            @(negedge wr_clk);
            wr_en = 1'b1;
            if (!wr_full) begin
                wr_data = seq;
                exp_q.push_back(seq);
                seq++;
                got++;
            end
        end
        @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    task automatic pull_words(input int n);
        int got = 0;
        while (got < n) begin
            @(negedge rd_clk);
            rd_en = 1'b0;
            if (!rd_empty && exp_q.size() != 0) begin
                check(rd_data == exp_q[0], "R10 concurrent order", rd_data, exp_q[0]);
                void'(exp_q.pop_front());
                rd_en = 1'b1;
                got++;
            end
        end
        @(negedge rd_clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge wr_clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired");
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int waited;
        // R1: flags during and after reset
        repeat (3) @(negedge wr_clk);
        check(rd_empty == 1'b1, "R1 empty in reset", DATA_W'(rd_empty), 1);
        check(wr_full == 1'b0, "R1 full in reset", DATA_W'(wr_full), 0);
        wr_rst_n = 1'b1;
        rd_rst_n = 1'b1;
        settle();
        check(rd_empty == 1'b1, "R1 empty after reset", DATA_W'(rd_empty), 1);
        check(wr_full == 1'b0, "R1 full after reset", DATA_W'(wr_full), 0);

        // table walk: R2..R6, R9 (several laps of the storage)
        for (int s = 0; s < NSTEP; s++) begin
            if (STEPS[s][8]) do_write(int'(STEPS[s][7:2]));
            else             do_read(int'(STEPS[s][7:2]));
            settle();
            check(wr_full == STEPS[s][1], "R4 R5 full after step",
                  DATA_W'(wr_full), DATA_W'(STEPS[s][1]));
            check(rd_empty == STEPS[s][0], "R3 R6 empty after step",
                  DATA_W'(rd_empty), DATA_W'(STEPS[s][0]));
        end

        // R8: empty clears only after the write pointer crosses over
        @(negedge wr_clk);
        wr_en = 1'b1;
        wr_data = 32'hCAFE_0001;
        exp_q.push_back(32'hCAFE_0001);
        @(posedge wr_clk);
        #0.1 wr_en = 1'b0;
        @(negedge rd_clk);
        check(rd_empty == 1'b1, "R8 empty held one cycle", DATA_W'(rd_empty), 1);
        waited = 0;
        while (rd_empty && waited < 6) begin
            @(negedge rd_clk);
            waited++;
        end
        check(rd_empty == 1'b0, "R8 empty cleared", DATA_W'(rd_empty), 0);
        check(rd_data == 32'hCAFE_0001, "R8 R2 word shown before pop", rd_data, 32'hCAFE_0001);
        do_read(1);
        settle();

        // R7: full clears only after the read pointer crosses over
        do_write(DEPTH);
        settle();
        @(negedge rd_clk);
        rd_en = 1'b1;
        void'(exp_q.pop_front());
        @(posedge rd_clk);
        #0.1 rd_en = 1'b0;
        @(negedge wr_clk);
        check(wr_full == 1'b1, "R7 full held one cycle", DATA_W'(wr_full), 1);
        waited = 0;
        while (wr_full && waited < 6) begin
            @(negedge wr_clk);
            waited++;
        end
        check(wr_full == 1'b0, "R7 full cleared", DATA_W'(wr_full), 0);
        do_read(DEPTH - 1);
        settle();

        // R10: both sides running together
        fork
            push_words(40);
            pull_words(40);
        join
        settle();
        check(rd_empty == 1'b1, "R10 drained at end", DATA_W'(rd_empty), 1);
        check(wr_full == 1'b0, "R10 not full at end", DATA_W'(wr_full), 0);

        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule